// File: doc/BRIEF.md
# Pipelined Burst SRAM Controller

This block is the control and address front end of a small pipelined synchronous burst memory, with the storage array included. On every rising clock edge it looks at two active-low address strobes, three chip enables, a burst-advance input, a global write input and per-lane write enables. When a strobe is accepted it loads a fresh address and starts a read, a write, or a deselect. The read/write choice depends on which strobe is used and on the enables.

Once an access is running, the two low address bits walk through a four-beat burst. The order is linear or interleaved and is chosen by a static mode input. Array accesses are pipelined. The access for the address held during a cycle happens at the closing edge of that cycle. Read data is registered there, so it appears one clock after the address is loaded. Write data and lane enables for a beat are sampled at that same closing edge. A new strobe may arrive in the last data cycle of a burst: that edge performs the last beat and also loads the next command.

The processor strobe always reads and has priority. The controller strobe reads or writes. Either strobe can put the device into the deselected state, in which the outputs are held at zero.

Top module: `sram_burst_ctl`

## Requirements
- R1: The processor strobe (`proc_strobe_ni` low) is accepted when `en_prim_ni` is low. With `en_hi_i` high and `en_lo_ni` low it loads `addr_i` and starts a read. One edge after the load, `rvalid_o` is 1 and `rdata_o` holds the word at that address.
- R2: An accepted processor strobe is always a read, even if `gw_ni`, `byte_we_ni` or `ctrl_strobe_ni` are low in the same cycle. It takes priority over the controller strobe, and the memory is not written.
- R3: While `en_prim_ni` is high, the processor strobe is ignored. If the controller strobe is also high, the address, burst position and access state are all unchanged.
- R4: An accepted processor strobe with `en_hi_i` low or `en_lo_ni` high deselects the device instead of reading.
- R5: The controller strobe (`ctrl_strobe_ni` low, processor strobe not accepted) loads `addr_i` when all three enables are asserted. It starts a write if `gw_ni` is low or any `byte_we_ni` bit is low at that edge, and a read otherwise.
- R6: The controller strobe with `en_prim_ni` high, or with either secondary enable off, deselects the device.
- R7: In a write access, each edge after the load writes `wdata_i` to the current address. If `gw_ni` is low, every lane is written. Otherwise lane k (bits [k*9+8:k*9]) is written only when `byte_we_ni[k]` is low.
- R8: With `mode_i` = 0 the two low address bits are (start + beat) mod 4. The upper address bits stay as loaded.
- R9: With `mode_i` = 1 the two low address bits are start XOR beat.
- R10: With no strobe accepted during an access, `adv_ni` low steps the burst by one beat at the edge. `adv_ni` high holds the address, so the same word is accessed again.
- R11: After reset, `rvalid_o` and `rdata_o` are 0. `rvalid_o` is 1 only in the cycle after a read access edge.
- R12: One edge after a deselect is registered, `rvalid_o` and `rdata_o` are 0. They stay 0 while deselected, whatever `adv_ni` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| proc_strobe_ni | input | 1 | Processor address strobe, active low, read only |
| ctrl_strobe_ni | input | 1 | Controller address strobe, active low, read or write |
| en_prim_ni | input | 1 | Primary chip enable, active low |
| en_hi_i | input | 1 | Secondary chip enable, active high |
| en_lo_ni | input | 1 | Secondary chip enable, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write of all lanes, active low |
| byte_we_ni | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
On every cycle, the assertions check the following:
- The next burst offset follows from the current one in both orders, and a held burst keeps its address.
- An ignored processor strobe leaves the access state untouched.
- Each accepted strobe has the right one-edge-delayed effect on `rvalid_o`, and a deselect zeroes the outputs.

Only the bench's scenarios show what the array actually returns. Those cover:
- the word order of full bursts in both modes, with start offsets that tell the two orders apart;
- that the write controls cannot corrupt data under a processor read;
- that a masked lane write keeps the other lane;
- that an ignored strobe keeps reading the old address.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_START_RD,
    ACT_START_WR,
    ACT_DESEL
  } act_e;
endpackage

// File: rtl/sram_strobe_dec.sv
module sram_strobe_dec
  import sram_burst_pkg::*;
(
  input  logic proc_strobe_ni,
  input  logic ctrl_strobe_ni,
  input  logic en_prim_ni,
  input  logic en_hi_i,
  input  logic en_lo_ni,
  input  logic wr_req_i,
  output act_e act_o
);
  logic sec_ok;
  assign sec_ok = en_hi_i & ~en_lo_ni;

  always_comb begin
    act_o = ACT_NONE;
    if (!proc_strobe_ni && !en_prim_ni) begin
      // processor strobe: read only, has priority
      act_o = sec_ok ? ACT_START_RD : ACT_DESEL;
    end else if (!ctrl_strobe_ni) begin
      if (!en_prim_ni && sec_ok) act_o = wr_req_i ? ACT_START_WR : ACT_START_RD;
      else                       act_o = ACT_DESEL;
    end
  end
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int BURST_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic               load_i,
  input  logic [BURST_W-1:0] start_i,
  input  logic               step_i,
  output logic [BURST_W-1:0] off_o
);
  logic [BURST_W-1:0] start_q, beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      beat_q  <= '0;
    end else if (step_i) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign off_o = mode_i ? (start_q ^ beat_q) : BURST_W'(start_q + beat_q);

  assert_linear_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !mode_i) |=> (off_o == BURST_W'($past(off_o) + 1'b1)));

  assert_interleave_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && mode_i) |=>
      ((off_o ^ start_q) == BURST_W'(($past(off_o) ^ $past(start_q)) + 1'b1)));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (acc_i && wr_i && lane_we_i[k]) mem_q[addr_i] <= wdata_i[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              rd_q <= '0;
      else if (acc_i && !wr_i)  rd_q <= mem_q[addr_i];
      else                      rd_q <= '0;
    end

    assign rdata_o[k*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= acc_i && !wr_i;
  end

  assert_idle_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> (!rvalid_o && rdata_o == '0));
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2,
  localparam int DW     = LANES * LANE_W,
  localparam int HI_W   = ADDR_W - BURST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              en_prim_ni,
  input  logic              en_hi_i,
  input  logic              en_lo_ni,
  input  logic              adv_ni,
  input  logic              gw_ni,
  input  logic [LANES-1:0]  byte_we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  act_e               act;
  logic               wr_req, load, step;
  logic               active_q, wr_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] off;
  logic [LANES-1:0]   lane_we;

  assign wr_req  = !gw_ni || !(&byte_we_ni);
  assign lane_we = gw_ni ? ~byte_we_ni : {LANES{1'b1}};
  assign load    = (act == ACT_START_RD) || (act == ACT_START_WR);
  assign step    = active_q && (act == ACT_NONE) && !adv_ni;

  sram_strobe_dec u_dec (
    .proc_strobe_ni (proc_strobe_ni),
    .ctrl_strobe_ni (ctrl_strobe_ni),
    .en_prim_ni     (en_prim_ni),
    .en_hi_i        (en_hi_i),
    .en_lo_ni       (en_lo_ni),
    .wr_req_i       (wr_req),
    .act_o          (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      hi_q     <= '0;
    end else begin
      unique case (act)
        ACT_START_RD: begin active_q <= 1'b1; wr_q <= 1'b0; hi_q <= addr_i[ADDR_W-1:BURST_W]; end
        ACT_START_WR: begin active_q <= 1'b1; wr_q <= 1'b1; hi_q <= addr_i[ADDR_W-1:BURST_W]; end
        ACT_DESEL:    begin active_q <= 1'b0; wr_q <= 1'b0; end
        default:      ;
      endcase
    end
  end

  sram_burst_seq #(.BURST_W(BURST_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .load_i  (load),
    .start_i (addr_i[BURST_W-1:0]),
    .step_i  (step),
    .off_o   (off)
  );

  sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (active_q),
    .wr_i      (wr_q),
    .addr_i    ({hi_q, off}),
    .lane_we_i (lane_we),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assert_proc_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && !en_prim_ni && en_hi_i && !en_lo_ni) |=> ##1 rvalid_o);

  assert_proc_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_prim_ni && ctrl_strobe_ni) |=> ($stable(active_q) && $stable(wr_q) && $stable(hi_q)));

  assert_proc_desel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && !en_prim_ni && (!en_hi_i || en_lo_ni)) |=> ##1 (!rvalid_o && rdata_o == '0));

  assert_ctrl_desel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_strobe_ni && proc_strobe_ni && en_prim_ni) |=> ##1 !rvalid_o);

  assert_hold_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && act == ACT_NONE && adv_ni) |=> ($stable(off) && $stable(hi_q)));
endmodule

// File: tb/sram_burst_ctl_tb.sv
module sram_burst_ctl_tb;
  localparam int AW = 6, LW = 9, NL = 2, DW = NL * LW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_i, proc_strobe_ni, ctrl_strobe_ni, en_prim_ni, en_hi_i, en_lo_ni;
  logic adv_ni, gw_ni;
  logic [NL-1:0] byte_we_ni;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic rvalid_o;
  logic [DW-1:0] model [1 << AW];
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  sram_burst_ctl u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [1:0] boff(logic [1:0] s, logic [1:0] b, logic m);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  task automatic idle();
    proc_strobe_ni = 1; ctrl_strobe_ni = 1; en_prim_ni = 0; en_hi_i = 1; en_lo_ni = 0;
    adv_ni = 1; gw_ni = 1; byte_we_ni = '1;
  endtask

  task automatic desel_now();
    ctrl_strobe_ni = 0; en_prim_ni = 1;
  endtask

  // R5 R7 R8 R9: full burst write with global write
  task automatic wr_burst(input logic [AW-1:0] base, input logic md, input logic [DW-1:0] seed);
    idle(); mode_i = md; ctrl_strobe_ni = 0; gw_ni = 0; addr_i = base;
    cyc();
    for (int b = 0; b < 4; b++) begin
      idle(); gw_ni = 0; adv_ni = 0; wdata_i = seed + DW'(b * 37);
      if (b == 3) desel_now();
      cyc();
      model[{base[AW-1:2], boff(base[1:0], 2'(b), md)}] = seed + DW'(b * 37);
      chk(!rvalid_o, "R11 no valid on write", DW'(rvalid_o), 0);
    end
    idle(); cyc();
  endtask

  // R1 R5 R8 R9 R10 R12: burst read, ends with controller deselect
  task automatic rd_burst(input logic [AW-1:0] base, input logic md, input bit use_proc, input string req);
    logic [AW-1:0] a;
    idle(); mode_i = md; addr_i = base;
    if (use_proc) proc_strobe_ni = 0; else ctrl_strobe_ni = 0;
    cyc();
    for (int b = 0; b < 4; b++) begin
      idle(); adv_ni = 0;
      if (b == 3) desel_now();
      cyc();
      a = {base[AW-1:2], boff(base[1:0], 2'(b), md)};
      chk(rvalid_o && rdata_o == model[a], req, rdata_o, model[a]);
    end
    idle(); adv_ni = 0; cyc();
    chk(!rvalid_o && rdata_o == '0, "R12 after R6 deselect", rdata_o, 0);
    cyc();
    chk(!rvalid_o && rdata_o == '0, "R12 adv while deselected", rdata_o, 0);
    idle();
  endtask

  task automatic t_reset();
    chk(!rvalid_o && rdata_o == '0, "R11 reset", rdata_o, 0);
  endtask

  // R10: hold with adv high
  task automatic t_hold();
    idle(); mode_i = 0; proc_strobe_ni = 0; addr_i = 6'h06; cyc();
    idle(); cyc();
    chk(rvalid_o && rdata_o == model[6'h06], "R10 hold beat", rdata_o, model[6'h06]);
    cyc();
    chk(rvalid_o && rdata_o == model[6'h06], "R10 hold again", rdata_o, model[6'h06]);
    desel_now(); cyc(); idle(); cyc();
  endtask

  // R2: processor read wins over write controls and controller strobe
  task automatic t_priority();
    idle(); mode_i = 0; proc_strobe_ni = 0; ctrl_strobe_ni = 0; gw_ni = 0; byte_we_ni = '0;
    addr_i = 6'h07; wdata_i = 18'h2AAAA; cyc();
    idle(); gw_ni = 0; byte_we_ni = '0; wdata_i = 18'h15555; cyc();
    chk(rvalid_o && rdata_o == model[6'h07], "R2 read despite write ctrl", rdata_o, model[6'h07]);
    cyc();
    chk(rvalid_o && rdata_o == model[6'h07], "R2 no write occurred", rdata_o, model[6'h07]);
    idle(); desel_now(); cyc(); idle(); cyc();
  endtask

  // R3: processor strobe ignored while primary enable high
  task automatic t_ignored();
    idle(); mode_i = 0; proc_strobe_ni = 0; addr_i = 6'h04; cyc();
    idle(); adv_ni = 0; cyc();
    chk(rvalid_o && rdata_o == model[6'h04], "R3 setup beat0", rdata_o, model[6'h04]);
    idle(); proc_strobe_ni = 0; en_prim_ni = 1; addr_i = 6'h29; cyc();
    chk(rvalid_o && rdata_o == model[6'h05], "R3 ignored strobe", rdata_o, model[6'h05]);
    cyc();
    chk(rvalid_o && rdata_o == model[6'h05], "R3 address kept", rdata_o, model[6'h05]);
    idle(); desel_now(); cyc(); idle(); cyc();
  endtask

  // R4: processor strobe with secondary enables off
  task automatic t_proc_desel();
    idle(); proc_strobe_ni = 0; addr_i = 6'h05; cyc();
    idle(); proc_strobe_ni = 0; en_hi_i = 0; cyc();
    chk(rvalid_o && rdata_o == model[6'h05], "R4 pre-desel read", rdata_o, model[6'h05]);
    idle(); cyc();
    chk(!rvalid_o && rdata_o == '0, "R4 en_hi low deselects", rdata_o, 0);
    idle(); proc_strobe_ni = 0; addr_i = 6'h05; cyc();
    idle(); proc_strobe_ni = 0; en_lo_ni = 1; cyc();
    idle(); cyc();
    chk(!rvalid_o && rdata_o == '0, "R4 en_lo high deselects", rdata_o, 0);
  endtask

  // R6: controller strobe with secondary enable off
  task automatic t_ctrl_sec();
    idle(); proc_strobe_ni = 0; addr_i = 6'h06; cyc();
    idle(); ctrl_strobe_ni = 0; en_hi_i = 0; cyc();
    idle(); cyc();
    chk(!rvalid_o && rdata_o == '0, "R6 secondary off deselects", rdata_o, 0);
  endtask

  // R7: lane writes
  task automatic t_lane(input logic [NL-1:0] be_n, input string req);
    logic [DW-1:0] exp;
    idle(); ctrl_strobe_ni = 0; byte_we_ni = be_n; addr_i = 6'h2A; cyc();
    idle(); byte_we_ni = be_n; wdata_i = 18'h3C3C3; desel_now(); cyc();
    for (int k = 0; k < NL; k++)
      if (!be_n[k]) model[6'h2A][k*LW +: LW] = wdata_i[k*LW +: LW];
    idle(); cyc();
    proc_strobe_ni = 0; addr_i = 6'h2A; cyc();
    idle(); desel_now(); cyc();
    exp = model[6'h2A];
    chk(rvalid_o && rdata_o == exp, req, rdata_o, exp);
    idle(); cyc();
  endtask

  initial begin
    idle(); mode_i = 0; addr_i = '0; wdata_i = '0;
    repeat (3) cyc();
    t_reset();
    rst_ni = 1; cyc();
    t_reset();
    wr_burst(6'h05, 1'b0, 18'h01234);
    rd_burst(6'h05, 1'b0, 1'b1, "R1 R8 linear proc read");
    wr_burst(6'h29, 1'b1, 18'h0ABCD);
    rd_burst(6'h29, 1'b1, 1'b0, "R5 R9 interleaved ctrl read");
    rd_burst(6'h2B, 1'b0, 1'b1, "R8 R10 linear wrap");
    rd_burst(6'h06, 1'b1, 1'b1, "R9 interleaved start2");
    t_hold();
    t_priority();
    t_ignored();
    t_proc_desel();
    t_ctrl_sec();
    t_lane(2'b10, "R7 lane0 only");
    t_lane(2'b01, "R7 lane1 only");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule